// File: doc/BRIEF.md
# PHY Discovery and Link Resolver

This block brings up an Ethernet link over a station-management port. A `start` pulse makes it probe every PHY address in turn, beginning at 0 and counting up, by reading the PHY identifier register (register 2). An address is passed over when its read times out or when it returns all zeros or all ones. The first address that gives any other value is taken as the PHY.

The block then reads the PHY's own advertisement register (register 4) and the partner ability register (register 5). It keeps only the partner bits `0x03E0`, ANDs them with the advertisement, and from the common set derives the 100 Mb/s bit (13) and the full-duplex bit (8) of a control word. If the partner reports no abilities and `force_en` is high, the forced speed and duplex replace the resolved bits and are written to register 0. If no address answers, the block reports not-found and selects the serial no-PHY mode.

Each management request is held on `mdio_req` until `mdio_ack`. A timeout ends a request that gets no acknowledge, and that read counts as failed. `done` pulses for one cycle when a run ends.

States: IDLE (waiting for start), PROBE (identifier read at the scan address), OWN_ADV (register 4 read), PART_ABIL (register 5 read), FORCE_WR (register 0 write), REPORT (done cycle). Transitions:
- IDLE→PROBE on `start`.
- PROBE→PROBE at the next address on a miss.
- PROBE→OWN_ADV on a hit.
- PROBE→REPORT on a miss at the last address.
- OWN_ADV→PART_ABIL when the read completes.
- PART_ABIL→FORCE_WR when the masked partner value is zero and `force_en` is high.
- PART_ABIL→REPORT otherwise.
- FORCE_WR→REPORT when the write completes.
- REPORT→IDLE always.

Top module: `phy_link_resolver`

## Requirements
- R1: Identifier reads go to register 2 at addresses 0, 1, 2, … in ascending order. The first address whose read succeeds with a value other than 0x0000 or 0xFFFF is reported on `phy_addr`, `phy_found` is 1, and no further address is probed.
- R2: An address whose identifier read returns 0x0000 or 0xFFFF is skipped.
- R3: `speed100` (control bit 13, value 0x2000) is 1 when (reg4 AND reg5 AND 0x03E0) has any bit of 0x0380 set.
- R4: `full_duplex` (control bit 8, value 0x0100) is 1 when that common set has any bit of 0x0140 set. Partner bits outside 0x03E0 have no effect.
- R5: `ctrl_word` carries `speed100` at bit 13 and `full_duplex` at bit 8, with all other bits zero.
- R6: When the masked partner value is zero and `force_en` is 1, exactly one write goes to register 0 of the found PHY. Its data has bit 13 = `force_speed100` and bit 8 = `force_full`, and the reported bits equal the forced ones.
- R7: When the masked partner value is nonzero, or `force_en` is 0, no write is issued.
- R8: When no address answers after address 31, `phy_found` = 0, `serial_mode` = 1, and `speed100` = `full_duplex` = 0.
- R9: A request with no acknowledge is dropped after TIMEOUT cycles and treated as a failed read; the scan continues.
- R10: `done` is high for exactly one cycle per run. `start` while `busy` (including the done cycle) does not restart or extend the run.
- R11: After reset, `busy`, `done`, `mdio_req`, `phy_found`, `serial_mode` and `ctrl_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a discovery run |
| force_en | input | 1 | Allow forced mode when the partner has no abilities |
| force_speed100 | input | 1 | Forced 100 Mb/s selection |
| force_full | input | 1 | Forced full-duplex selection |
| mdio_req | output | 1 | Management request, held until ack or timeout |
| mdio_we | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | ADDR_W | PHY address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_wdata | output | DATA_W | Write data |
| mdio_ack | input | 1 | Request completed (one cycle) |
| mdio_rdata | input | DATA_W | Read data, valid with ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| phy_found | output | 1 | A PHY was found |
| phy_addr | output | ADDR_W | Address of the found PHY |
| speed100 | output | 1 | Resolved or forced 100 Mb/s |
| full_duplex | output | 1 | Resolved or forced full duplex |
| serial_mode | output | 1 | No PHY found; serial mode selected |
| ctrl_word | output | DATA_W | Control-register value |

## Verification
Two events can land in the same cycle: the end of a run, signalled by `done`, and a fresh `start` request. The bench raises `start` in the exact cycle `done` is seen. It then checks that `busy` falls the next cycle and that no new identifier read follows. It also pulses `start` in the middle of a scan and judges the result by the count and order of the probes.

// File: rtl/phy_res_pkg.sv
package phy_res_pkg;
    localparam int REG_W = 5;

    localparam logic [REG_W-1:0] RA_CTRL = 5'd0;
    localparam logic [REG_W-1:0] RA_ID   = 5'd2;
    localparam logic [REG_W-1:0] RA_OWN  = 5'd4;
    localparam logic [REG_W-1:0] RA_PART = 5'd5;

    localparam int SPD_BIT = 13;
    localparam int DUP_BIT = 8;

    localparam logic [15:0] PART_MASK = 16'h03E0;
    localparam logic [15:0] MASK_100  = 16'h0380;
    localparam logic [15:0] MASK_FULL = 16'h0140;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_OWN_ADV,
        ST_PART_ABIL,
        ST_FORCE_WR,
        ST_REPORT
    } res_state_t;
endpackage

// File: rtl/res_mdio_txn.sv
module res_mdio_txn
    import phy_res_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_phy,
    input  logic [REG_W-1:0]  go_reg,
    input  logic [DATA_W-1:0] go_wdata,
    output logic              mdio_req,
    output logic              mdio_we,
    output logic [ADDR_W-1:0] mdio_phy,
    output logic [REG_W-1:0]  mdio_reg,
    output logic [DATA_W-1:0] mdio_wdata,
    input  logic              mdio_ack,
    input  logic [DATA_W-1:0] mdio_rdata,
    output logic              fin,
    output logic              fin_ok,
    output logic [DATA_W-1:0] fin_data
);
    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_req   <= 1'b0;
            mdio_we    <= 1'b0;
            mdio_phy   <= '0;
            mdio_reg   <= '0;
            mdio_wdata <= '0;
            wait_cnt   <= '0;
            fin        <= 1'b0;
            fin_ok     <= 1'b0;
            fin_data   <= '0;
        end else begin
            fin <= 1'b0;
            if (mdio_req) begin
                if (mdio_ack) begin
                    mdio_req <= 1'b0;
                    fin      <= 1'b1;
                    fin_ok   <= 1'b1;
                    fin_data <= mdio_rdata;
                end else if (wait_cnt == CNT_LAST) begin
                    mdio_req <= 1'b0;
                    fin      <= 1'b1;
                    fin_ok   <= 1'b0;
                    fin_data <= '0;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end else if (go) begin
                mdio_req   <= 1'b1;
                mdio_we    <= go_we;
                mdio_phy   <= go_phy;
                mdio_reg   <= go_reg;
                mdio_wdata <= go_wdata;
                wait_cnt   <= '0;
            end
        end
    end
endmodule

// File: rtl/res_ability_merge.sv
module res_ability_merge
    import phy_res_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] own_adv,
    input  logic [DATA_W-1:0] part_raw,
    output logic [DATA_W-1:0] part_masked,
    output logic              sel_100,
    output logic              sel_full
);
    logic [DATA_W-1:0] shared;

    always_comb begin
        part_masked = part_raw & DATA_W'(PART_MASK);
        shared      = own_adv & part_masked;
        sel_100     = |(shared & DATA_W'(MASK_100));
        sel_full    = |(shared & DATA_W'(MASK_FULL));
    end
endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver
    import phy_res_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              force_en,
    input  logic              force_speed100,
    input  logic              force_full,
    output logic              mdio_req,
    output logic              mdio_we,
    output logic [ADDR_W-1:0] mdio_phy,
    output logic [4:0]        mdio_reg,
    output logic [DATA_W-1:0] mdio_wdata,
    input  logic              mdio_ack,
    input  logic [DATA_W-1:0] mdio_rdata,
    output logic              busy,
    output logic              done,
    output logic              phy_found,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              speed100,
    output logic              full_duplex,
    output logic              serial_mode,
    output logic [DATA_W-1:0] ctrl_word
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    res_state_t state_q, state_d;

    logic              go, go_we;
    logic [ADDR_W-1:0] go_phy;
    logic [REG_W-1:0]  go_reg;
    logic [DATA_W-1:0] go_wdata;
    logic              fin, fin_ok;
    logic [DATA_W-1:0] fin_data;

    logic [ADDR_W-1:0] scan_q;
    logic [DATA_W-1:0] own_q;
    logic [DATA_W-1:0] part_raw, part_masked;
    logic              sel_100, sel_full;
    logic              id_hit, part_zero, take_force;
    logic [DATA_W-1:0] forced_word;

    res_mdio_txn #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_txn (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .go_we      (go_we),
        .go_phy     (go_phy),
        .go_reg     (go_reg),
        .go_wdata   (go_wdata),
        .mdio_req   (mdio_req),
        .mdio_we    (mdio_we),
        .mdio_phy   (mdio_phy),
        .mdio_reg   (mdio_reg),
        .mdio_wdata (mdio_wdata),
        .mdio_ack   (mdio_ack),
        .mdio_rdata (mdio_rdata),
        .fin        (fin),
        .fin_ok     (fin_ok),
        .fin_data   (fin_data)
    );

    assign part_raw = fin_ok ? fin_data : '0;

    res_ability_merge #(.DATA_W(DATA_W)) u_merge (
        .own_adv     (own_q),
        .part_raw    (part_raw),
        .part_masked (part_masked),
        .sel_100     (sel_100),
        .sel_full    (sel_full)
    );

    assign id_hit     = fin_ok && (fin_data != '0) && (fin_data != '1);
    assign part_zero  = (part_masked == '0);
    assign take_force = part_zero && force_en;

    always_comb begin
        forced_word          = '0;
        forced_word[SPD_BIT] = force_speed100;
        forced_word[DUP_BIT] = force_full;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and request issue
    always_comb begin
        state_d  = state_q;
        go       = 1'b0;
        go_we    = 1'b0;
        go_phy   = phy_addr;
        go_reg   = RA_ID;
        go_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PROBE;
                    go      = 1'b1;
                    go_phy  = '0;
                end
            end
            ST_PROBE: begin
                if (fin) begin
                    if (id_hit) begin
                        state_d = ST_OWN_ADV;
                        go      = 1'b1;
                        go_phy  = scan_q;
                        go_reg  = RA_OWN;
                    end else if (scan_q == LAST_ADDR) begin
                        state_d = ST_REPORT;
                    end else begin
                        go     = 1'b1;
                        go_phy = scan_q + 1'b1;
                    end
                end
            end
            ST_OWN_ADV: begin
                if (fin) begin
                    state_d = ST_PART_ABIL;
                    go      = 1'b1;
                    go_reg  = RA_PART;
                end
            end
            ST_PART_ABIL: begin
                if (fin) begin
                    if (take_force) begin
                        state_d  = ST_FORCE_WR;
                        go       = 1'b1;
                        go_we    = 1'b1;
                        go_reg   = RA_CTRL;
                        go_wdata = forced_word;
                    end else begin
                        state_d = ST_REPORT;
                    end
                end
            end
            ST_FORCE_WR: begin
                if (fin) state_d = ST_REPORT;
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Result and scan registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q      <= '0;
            phy_addr    <= '0;
            phy_found   <= 1'b0;
            own_q       <= '0;
            speed100    <= 1'b0;
            full_duplex <= 1'b0;
            serial_mode <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        scan_q      <= '0;
                        phy_addr    <= '0;
                        phy_found   <= 1'b0;
                        own_q       <= '0;
                        speed100    <= 1'b0;
                        full_duplex <= 1'b0;
                        serial_mode <= 1'b0;
                    end
                end
                ST_PROBE: begin
                    if (fin) begin
                        if (id_hit) begin
                            phy_found <= 1'b1;
                            phy_addr  <= scan_q;
                        end else if (scan_q == LAST_ADDR) begin
                            serial_mode <= 1'b1;
                        end else begin
                            scan_q <= scan_q + 1'b1;
                        end
                    end
                end
                ST_OWN_ADV: begin
                    if (fin) own_q <= part_raw;
                end
                ST_PART_ABIL: begin
                    if (fin) begin
                        speed100    <= take_force ? force_speed100 : sel_100;
                        full_duplex <= take_force ? force_full     : sel_full;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy                 = (state_q != ST_IDLE);
        done                 = (state_q == ST_REPORT);
        ctrl_word            = '0;
        ctrl_word[SPD_BIT]   = speed100;
        ctrl_word[DUP_BIT]   = full_duplex;
    end
endmodule

// File: rtl/res_checker.sv
module res_checker
    import phy_res_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             mdio_req,
    input logic             mdio_we,
    input logic [REG_W-1:0] mdio_reg,
    input logic             phy_found,
    input logic             serial_mode,
    input logic             speed100,
    input logic             full_duplex
);
    localparam int HC_W = $clog2(TIMEOUT + 1) + 1;

    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_cnt <= '0;
        else if (mdio_req) hi_cnt <= hi_cnt + 1'b1;
        else               hi_cnt <= '0;
    end

    // R9: no request stays up beyond the timeout window
    p_req_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req |-> (hi_cnt < HC_W'(TIMEOUT)));

    // R10: done lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: start during a run does not end or restart it
    p_start_held_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy);

    // R8: not-found reporting
    p_absent_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !phy_found) |-> (serial_mode && !speed100 && !full_duplex));

    // R1: found PHY never reports serial mode
    p_found_not_serial_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && phy_found) |-> !serial_mode);

    // R1: requests before discovery are identifier reads
    p_probe_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !phy_found) |-> (!mdio_we && mdio_reg == RA_ID));

    // R6: writes only target the control register
    p_write_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_we) |-> (mdio_reg == RA_CTRL));
endmodule

bind phy_link_resolver res_checker #(.TIMEOUT(TIMEOUT)) u_chk (.*);

// File: tb/sim_phy_link_resolver.sv
`timescale 1ns/1ps
module sim_phy_link_resolver;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int TIMEOUT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, force_en = 1'b0, force_speed100 = 1'b0, force_full = 1'b0;
    logic mdio_req, mdio_we;
    logic [ADDR_W-1:0] mdio_phy;
    logic [4:0] mdio_reg;
    logic [DATA_W-1:0] mdio_wdata;
    logic mdio_ack = 1'b0;
    logic [DATA_W-1:0] mdio_rdata = '0;
    logic busy, done, phy_found, speed100, full_duplex, serial_mode;
    logic [ADDR_W-1:0] phy_addr;
    logic [DATA_W-1:0] ctrl_word;

    always #2 clk = ~clk;

    phy_link_resolver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u0 (.*);

    // PHY model
    logic [15:0] phy_id [32];
    logic        noack  [32];
    logic [15:0] adv_v = '0, lp_v = '0;
    logic clr_stats = 1'b0;
    int lat_cnt = 0, probe_cnt = 0, last_probe = 0, wr_cnt = 0;
    bit order_bad = 0, prev_req = 0;
    logic [4:0] wr_phy = '0, wr_reg = '0;
    logic [15:0] wr_data = '0;

    always @(posedge clk) begin
        mdio_ack <= 1'b0;
        prev_req <= mdio_req;
        if (clr_stats) begin
            probe_cnt <= 0; order_bad <= 0; wr_cnt <= 0; last_probe <= 0;
        end else if (mdio_req && !prev_req && !mdio_we && mdio_reg == 5'd2) begin
            if ((probe_cnt == 0 && mdio_phy != 0) ||
                (probe_cnt > 0 && int'(mdio_phy) != last_probe + 1)) order_bad <= 1;
            probe_cnt  <= probe_cnt + 1;
            last_probe <= int'(mdio_phy);
        end
        if (!mdio_req) lat_cnt <= 0;
        else if (!mdio_ack) begin
            if (lat_cnt < 2) lat_cnt <= lat_cnt + 1;
            else if (!(mdio_reg == 5'd2 && !mdio_we && noack[mdio_phy])) begin
                mdio_ack <= 1'b1;
                lat_cnt  <= 0;
                if (mdio_we) begin
                    wr_cnt <= wr_cnt + 1; wr_phy <= mdio_phy;
                    wr_reg <= mdio_reg;   wr_data <= mdio_wdata;
                end else begin
                    case (mdio_reg)
                        5'd2:    mdio_rdata <= phy_id[mdio_phy];
                        5'd4:    mdio_rdata <= adv_v;
                        5'd5:    mdio_rdata <= lp_v;
                        default: mdio_rdata <= 16'hDEAD;
                    endcase
                end
            end
        end
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_map();
        for (int i = 0; i < 32; i++) begin phy_id[i] = 16'h0000; noack[i] = 1'b0; end
        @(negedge clk) clr_stats = 1'b1;
        @(negedge clk) clr_stats = 1'b0;
    endtask

    task automatic run_and_wait();
        int n = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        if (!done) chk("R10 done never seen", 0, 1);
    endtask

    task automatic check_result(input string tag, input bit exp_found, input int exp_addr);
        logic [15:0] shared;
        bit es, ef;
        shared = adv_v & lp_v & 16'h03E0;
        es = |(shared & 16'h0380);
        ef = |(shared & 16'h0140);
        if (exp_found && (lp_v & 16'h03E0) == 0 && force_en) begin
            es = force_speed100; ef = force_full;
        end
        if (!exp_found) begin es = 0; ef = 0; end
        chk({tag, " R1 found"}, phy_found, exp_found);
        if (exp_found) chk({tag, " R1 addr"}, phy_addr, exp_addr);
        chk({tag, " R3 speed"}, speed100, es);
        chk({tag, " R4 duplex"}, full_duplex, ef);
        chk({tag, " R5 ctrl"}, ctrl_word, (int'(es) << 13) | (int'(ef) << 8));
        chk({tag, " R8 serial"}, serial_mode, !exp_found);
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, done, 0);
        chk({tag, " R10 idle"}, busy, 0);
    endtask

    task automatic t_basic();
        clear_map();
        phy_id[0] = 16'hFFFF; phy_id[5] = 16'h02A8;
        adv_v = 16'h01E1; lp_v = 16'h45E1; force_en = 0;
        run_and_wait();
        check_result("basic", 1, 5);
        chk("R1 probe count", probe_cnt, 6);
        chk("R1 order", order_bad, 0);
        chk("R2 skip all-ones", phy_addr, 5);
        chk("R7 no write", wr_cnt, 0);
    endtask

    task automatic t_half10();
        clear_map();
        phy_id[2] = 16'h0013;
        adv_v = 16'h0061; lp_v = 16'h0021;
        run_and_wait();
        check_result("ten_half", 1, 2);
    endtask

    task automatic t_full10_mask();
        clear_map();
        phy_id[1] = 16'h1234;
        adv_v = 16'h0141; lp_v = 16'hFC5F;
        run_and_wait();
        check_result("R4 mask", 1, 1);
    endtask

    task automatic t_force();
        clear_map();
        phy_id[7] = 16'h7777;
        adv_v = 16'h01E1; lp_v = 16'h001F;
        force_en = 1; force_speed100 = 1; force_full = 0;
        run_and_wait();
        check_result("R6 force", 1, 7);
        chk("R6 write count", wr_cnt, 1);
        chk("R6 write reg", wr_reg, 0);
        chk("R6 write phy", wr_phy, 7);
        chk("R6 write data", wr_data, 16'h2000);
    endtask

    task automatic t_force_ignored();
        clear_map();
        phy_id[4] = 16'h4444;
        adv_v = 16'h0021; lp_v = 16'h0021;
        force_en = 1; force_speed100 = 1; force_full = 1;
        run_and_wait();
        check_result("R7 partner set", 1, 4);
        chk("R7 no write", wr_cnt, 0);
        clear_map();
        phy_id[4] = 16'h4444; lp_v = 16'h0000; force_en = 0;
        run_and_wait();
        check_result("R7 force off", 1, 4);
        chk("R7 no write off", wr_cnt, 0);
    endtask

    task automatic t_timeout();
        clear_map();
        noack[0] = 1; noack[1] = 1; noack[2] = 1; phy_id[3] = 16'h0F0F;
        adv_v = 16'h0181; lp_v = 16'h0181; force_en = 0;
        run_and_wait();
        check_result("R9 timeout", 1, 3);
        chk("R9 probe count", probe_cnt, 4);
    endtask

    task automatic t_last_addr();
        clear_map();
        phy_id[31] = 16'h0001;
        adv_v = 16'h0101; lp_v = 16'h0101;
        run_and_wait();
        check_result("R1 last", 1, 31);
        chk("R1 last probes", probe_cnt, 32);
    endtask

    task automatic t_absent();
        clear_map();
        for (int i = 0; i < 32; i++) phy_id[i] = (i % 2) ? 16'hFFFF : 16'h0000;
        run_and_wait();
        check_result("R8 absent", 0, 0);
        chk("R8 probes", probe_cnt, 32);
        chk("R8 order", order_bad, 0);
    endtask

    task automatic t_start_busy();
        clear_map();
        phy_id[3] = 16'h3333; adv_v = 16'h0021; lp_v = 16'h0021; force_en = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (8) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R10 start in done cycle ignored", busy, 0);
        repeat (10) @(negedge clk);
        chk("R10 probe count", probe_cnt, 4);
        chk("R10 order", order_bad, 0);
        chk("R10 still idle", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin phy_id[i] = 16'h0000; noack[i] = 1'b0; end
        repeat (3) @(negedge clk);
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 req", mdio_req, 0);
        chk("R11 found", phy_found, 0);
        chk("R11 serial", serial_mode, 0);
        chk("R11 ctrl", ctrl_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_half10();
        t_full10_mask();
        t_force();
        force_en = 0; force_speed100 = 0; force_full = 0;
        t_force_ignored();
        t_timeout();
        t_last_addr();
        t_absent();
        t_start_busy();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule